// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block generates the noise voice of a sound unit. A shift register with XOR feedback produces a pseudo-random bit stream. The register can run at full 15-bit length or be cut to a 7-bit loop, which gives a short, buzzy, periodic pattern. The register advances at a programmable rate. That rate is derived from a base clock enable through a small divide ratio and a power-of-two shift. Each output bit gates a 4-bit volume that a stepped envelope can raise or lower over time. An optional length counter silences the voice after a programmed number of length ticks.

Software programs the voice through two 16-bit write ports. The envelope port carries the start volume, the envelope direction, the envelope period and the length. The frequency port carries the divide ratio, the shift, the width select, the timed flag and the trigger bit. A write with the trigger bit set restarts the voice. The block also derives its own length tick and envelope tick from the base enable, every `LEN_DIV` base ticks and every `ENV_MUL` length ticks respectively. Mixing and panning belong to the next stage.

Top module: `noise_channel`

## Requirements
- R1: After reset, `active` is 0 and `amp` is 0.
- R2: A frequency write with bit 9 set (trigger) sets `active` and reloads the shift register to all ones. It also loads the volume with the start volume (envelope bits [3:0]), restarts the rate divider, sets the envelope timer to the envelope period, and loads the length counter. All of this happens in the write cycle.
- R3: The shift register advances once every r·2^(s+1) base ticks. Here r is frequency bits [2:0] and s is frequency bits [6:3]; r = 0 counts as one half, giving 2^s base ticks. The first advance comes that many base ticks after the trigger.
- R4: On each advance, the XOR of bits 0 and 1 enters bit 14 and the rest shifts down by one. The output bit is the inverse of bit 0. In 15-bit mode, the first 1 output after a trigger follows the 15th advance.
- R5: With frequency bit 7 set, the feedback bit is also written into bit 6, giving a 7-bit loop. The first 1 output after a trigger then follows the 7th advance.
- R6: `amp` equals the current volume when `active` is 1 and the output bit is 1; otherwise `amp` is 0.
- R7: With frequency bit 8 (timed) set, the length counter starts at 64 minus envelope bits [13:8] and counts down once per length tick. `active` clears on the tick that brings the counter to 0.
- R8: With the timed bit clear, the length counter never clears `active`.
- R9: Envelope bits [7:5] give the number of envelope ticks between volume steps, and 0 freezes the volume. Bit 4 selects the direction: 1 raises the volume, 0 lowers it. The volume saturates at 15 and at 0.
- R10: A frequency write with bit 9 clear changes the stored settings only. It neither starts nor stops the voice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baseTick | input | 1 | Base-rate clock enable for the divider and tick generator |
| envWe | input | 1 | Envelope/length register write strobe |
| envData | input | 16 | Envelope/length write data |
| frqWe | input | 1 | Frequency/trigger register write strobe |
| frqData | input | 16 | Frequency/trigger write data |
| amp | output | 4 | Output amplitude |
| active | output | 1 | Voice is sounding |

## Verification
The noise function is tried with directed triggers in both widths, measuring how many cycles pass before the first nonzero amplitude. This count separates the 7-bit and 15-bit feedback paths. Repeating the measurement with ratio 0 and ratio 3 exposes errors in the half-ratio case and in the shift exponent. Timed and untimed notes show whether the length counter is gated by the timed flag. Rising and falling envelopes show saturation in each direction. A long random run with random base-tick gaps, writes and retriggers is compared cycle by cycle against a reference model in the bench. This run catches phase errors between the divider, the length tick and the envelope tick.

// File: rtl/noise_pkg.sv
package noise_pkg;

  localparam int LFSR_W     = 15;
  localparam int NARROW_TAP = 6;
  localparam int RATIO_W    = 3;
  localparam int SHIFT_W    = 4;
  localparam int VOL_W      = 4;
  localparam int EPER_W     = 3;
  localparam int LEN_W      = 6;
  // widest divider period: (2*7) << 15 needs RATIO_W+1+(2^SHIFT_W-1) bits
  localparam int PER_W      = RATIO_W + 1 + (2 ** SHIFT_W) - 1;

  // frequency-port field positions
  localparam int F_RATIO_LO = 0;
  localparam int F_SHIFT_LO = 3;
  localparam int F_NARROW   = 7;
  localparam int F_TIMED    = 8;
  localparam int F_TRIG     = 9;
  // envelope-port field positions
  localparam int E_VOL_LO   = 0;
  localparam int E_UP       = 4;
  localparam int E_PER_LO   = 5;
  localparam int E_LEN_LO   = 8;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [SHIFT_W-1:0] shiftExp;
    logic               narrow;
    logic               timed;
    logic [VOL_W-1:0]   startVol;
    logic               envUp;
    logic [EPER_W-1:0]  envPeriod;
    logic [LEN_W-1:0]   lenVal;
  } cfg_t;

  typedef struct packed {
    logic restart;
    logic envStep;
  } strobe_t;

endpackage

// File: rtl/noise_ctrl.sv
module noise_ctrl
  import noise_pkg::*;
#(
  parameter int LEN_DIV = 2048,
  parameter int ENV_MUL = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baseTick,
  input  logic        envWe,
  input  logic [15:0] envData,
  input  logic        frqWe,
  input  logic [15:0] frqData,
  output cfg_t        cfgQ,
  output cfg_t        cfgNow,
  output strobe_t     stb,
  output logic        active
);

  localparam int FW = (LEN_DIV > 1) ? $clog2(LEN_DIV) : 1;
  localparam int SW = (ENV_MUL > 1) ? $clog2(ENV_MUL) : 1;
  localparam int CW = LEN_W + 1;

  logic [FW-1:0]     frameCnt;
  logic [SW-1:0]     subCnt;
  logic [CW-1:0]     lenCnt;
  logic [EPER_W-1:0] envTimer;
  logic              lenTick;
  logic              envTick;
  logic              restart;
  logic              lenRun;
  logic              unusedBits;

  assign unusedBits = ^{envData[15:14], frqData[15:10]};

  // settings as they stand after this cycle's writes
  always_comb begin
    cfgNow = cfgQ;
    if (envWe) begin
      cfgNow.startVol  = envData[E_VOL_LO +: VOL_W];
      cfgNow.envUp     = envData[E_UP];
      cfgNow.envPeriod = envData[E_PER_LO +: EPER_W];
      cfgNow.lenVal    = envData[E_LEN_LO +: LEN_W];
    end
    if (frqWe) begin
      cfgNow.ratio    = frqData[F_RATIO_LO +: RATIO_W];
      cfgNow.shiftExp = frqData[F_SHIFT_LO +: SHIFT_W];
      cfgNow.narrow   = frqData[F_NARROW];
      cfgNow.timed    = frqData[F_TIMED];
    end
  end

  assign restart = frqWe & frqData[F_TRIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgQ <= '0;
    else        cfgQ <= cfgNow;
  end

  // tick generator
  assign lenTick = baseTick && (frameCnt == FW'(LEN_DIV - 1));
  assign envTick = lenTick && (subCnt == SW'(ENV_MUL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameCnt <= '0;
      subCnt   <= '0;
    end else begin
      if (baseTick) frameCnt <= lenTick ? '0 : frameCnt + 1'b1;
      if (lenTick)  subCnt   <= envTick ? '0 : subCnt + 1'b1;
    end
  end

  // length counter and voice state
  assign lenRun = lenTick && active && cfgQ.timed && (lenCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenCnt <= '0;
      active <= 1'b0;
    end else if (restart) begin
      lenCnt <= CW'(64) - {1'b0, cfgNow.lenVal};
      active <= 1'b1;
    end else if (lenRun) begin
      lenCnt <= lenCnt - 1'b1;
      if (lenCnt == CW'(1)) active <= 1'b0;
    end
  end

  // envelope timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      envTimer <= '0;
    end else if (restart) begin
      envTimer <= cfgNow.envPeriod;
    end else if (envTick && active && (cfgQ.envPeriod != '0)) begin
      if (envTimer <= EPER_W'(1)) envTimer <= cfgQ.envPeriod;
      else                        envTimer <= envTimer - 1'b1;
    end
  end

  assign stb.restart = restart;
  assign stb.envStep = envTick && active && !restart &&
                       (cfgQ.envPeriod != '0) && (envTimer <= EPER_W'(1));

endmodule

// File: rtl/noise_datapath.sv
module noise_datapath
  import noise_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baseTick,
  input  cfg_t               cfgQ,
  input  cfg_t               cfgNow,
  input  strobe_t            stb,
  input  logic               active,
  output logic [VOL_W-1:0]   amp,
  output logic [LFSR_W-1:0]  lfsrQ,
  output logic [VOL_W-1:0]   volQ
);

  logic [PER_W-1:0]  divCnt;
  logic [LFSR_W-1:0] lfsrNext;
  logic              feedback;
  logic              advance;
  logic              unusedCfg;

  assign unusedCfg = ^{cfgQ.timed, cfgQ.startVol, cfgQ.envPeriod, cfgQ.lenVal,
                       cfgNow.narrow, cfgNow.timed, cfgNow.envUp,
                       cfgNow.envPeriod, cfgNow.lenVal};

  function automatic logic [PER_W-1:0] periodOf(input cfg_t c);
    logic [PER_W-1:0] base;
    base = (c.ratio == '0) ? PER_W'(1) : PER_W'({c.ratio, 1'b0});
    return base << c.shiftExp;
  endfunction

  // rate divider
  assign advance = baseTick && (divCnt == '0) && !stb.restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              divCnt <= '0;
    else if (stb.restart)    divCnt <= periodOf(cfgNow) - 1'b1;
    else if (baseTick) begin
      if (divCnt == '0)      divCnt <= periodOf(cfgQ) - 1'b1;
      else                   divCnt <= divCnt - 1'b1;
    end
  end

  // shift register next state, one bit per generate slice
  assign feedback = lfsrQ[0] ^ lfsrQ[1];

  for (genvar i = 0; i < LFSR_W; i++) begin : g_bit
    if (i == LFSR_W - 1) begin : g_top
      assign lfsrNext[i] = feedback;
    end else if (i == NARROW_TAP) begin : g_tap
      assign lfsrNext[i] = cfgQ.narrow ? feedback : lfsrQ[i+1];
    end else begin : g_mid
      assign lfsrNext[i] = lfsrQ[i+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lfsrQ <= '1;
    else if (stb.restart) lfsrQ <= '1;
    else if (advance)     lfsrQ <= lfsrNext;
  end

  // volume envelope
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      volQ <= '0;
    end else if (stb.restart) begin
      volQ <= cfgNow.startVol;
    end else if (stb.envStep) begin
      if (cfgQ.envUp && (volQ != '1))       volQ <= volQ + 1'b1;
      else if (!cfgQ.envUp && (volQ != '0)) volQ <= volQ - 1'b1;
    end
  end

  assign amp = (active && !lfsrQ[0]) ? volQ : '0;

endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_pkg::*;
#(
  parameter int LEN_DIV = 2048,
  parameter int ENV_MUL = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baseTick,
  input  logic        envWe,
  input  logic [15:0] envData,
  input  logic        frqWe,
  input  logic [15:0] frqData,
  output logic [3:0]  amp,
  output logic        active
);

  cfg_t              cfgQ;
  cfg_t              cfgNow;
  strobe_t           stb;
  logic [LFSR_W-1:0] lfsrQ;
  logic [VOL_W-1:0]  volQ;

  noise_ctrl #(.LEN_DIV(LEN_DIV), .ENV_MUL(ENV_MUL)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .baseTick(baseTick),
    .envWe(envWe), .envData(envData), .frqWe(frqWe), .frqData(frqData),
    .cfgQ(cfgQ), .cfgNow(cfgNow), .stb(stb), .active(active)
  );

  noise_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .baseTick(baseTick),
    .cfgQ(cfgQ), .cfgNow(cfgNow), .stb(stb), .active(active),
    .amp(amp), .lfsrQ(lfsrQ), .volQ(volQ)
  );

endmodule

// File: rtl/noise_channel_chk.sv
module noise_channel_chk
  import noise_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frqWe,
  input logic [15:0]       frqData,
  input logic              active,
  input logic [3:0]        amp,
  input strobe_t           stb,
  input cfg_t              cfgQ,
  input logic [LFSR_W-1:0] lfsrQ,
  input logic [VOL_W-1:0]  volQ
);

  // R2
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frqWe && frqData[F_TRIG]) |=> (active && (lfsrQ == '1)));

  // R4
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsrQ != '0);

  // R6
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (amp == '0));

  // R8
  untimed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cfgQ.timed && !(frqWe && frqData[F_TIMED])) |=> active);

  // R9
  vol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.restart && !stb.envStep) |=> $stable(volQ));

  // R10
  no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(frqWe && frqData[F_TRIG])) |=> !active);

endmodule

bind noise_channel noise_channel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frqWe(frqWe), .frqData(frqData),
  .active(active), .amp(amp), .stb(stb), .cfgQ(cfgQ),
  .lfsrQ(lfsrQ), .volQ(volQ)
);

// File: tb/noise_channel_tb_top.sv
module noise_channel_tb_top;

  localparam int LEN_DIV = 4;
  localparam int ENV_MUL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baseTick = 1'b0;
  logic        envWe = 1'b0;
  logic [15:0] envData = '0;
  logic        frqWe = 1'b0;
  logic [15:0] frqData = '0;
  logic [3:0]  amp;
  logic        active;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit cmpOn = 1'b0;

  always #2 clk = ~clk;

  noise_channel #(.LEN_DIV(LEN_DIV), .ENV_MUL(ENV_MUL)) dut_i (
    .clk(clk), .rst_n(rst_n), .baseTick(baseTick),
    .envWe(envWe), .envData(envData), .frqWe(frqWe), .frqData(frqData),
    .amp(amp), .active(active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int perOf(input int r, input int s);
    return ((r == 0) ? 1 : 2 * r) << s;
  endfunction

  // reference model, built from the requirements
  int       mRat, mSh, mVol0, mPer, mLen;
  bit       mNar, mTim, mUp, mAct;
  int       mFrame, mSub, mCnt, mEnvT, mDiv, mVol;
  bit [14:0] mLfsr;

  always @(posedge clk or negedge rst_n) begin : model
    if (!rst_n) begin
      mRat <= 0; mSh <= 0; mVol0 <= 0; mPer <= 0; mLen <= 0;
      mNar <= 0; mTim <= 0; mUp <= 0; mAct <= 0;
      mFrame <= 0; mSub <= 0; mCnt <= 0; mEnvT <= 0; mDiv <= 0; mVol <= 0;
      mLfsr <= '1;
    end else begin : step
      int nRat, nSh, nVol0, nPer, nLen;
      bit nNar, nTim, nUp, trig, lt, et, fb;
      bit [14:0] nl;
      nRat = mRat; nSh = mSh; nNar = mNar; nTim = mTim;
      nVol0 = mVol0; nUp = mUp; nPer = mPer; nLen = mLen;
      if (envWe) begin
        nVol0 = envData[3:0]; nUp = envData[4];
        nPer = envData[7:5]; nLen = envData[13:8];
      end
      if (frqWe) begin
        nRat = frqData[2:0]; nSh = frqData[6:3];
        nNar = frqData[7]; nTim = frqData[8];
      end
      trig = frqWe && frqData[9];
      lt = baseTick && (mFrame == LEN_DIV - 1);
      et = lt && (mSub == ENV_MUL - 1);
      if (baseTick) mFrame <= lt ? 0 : mFrame + 1;
      if (lt) mSub <= et ? 0 : mSub + 1;
      if (trig) begin
        mAct <= 1; mCnt <= 64 - nLen; mEnvT <= nPer;
        mDiv <= perOf(nRat, nSh) - 1; mLfsr <= '1; mVol <= nVol0;
      end else begin
        if (lt && mAct && mTim && mCnt != 0) begin
          mCnt <= mCnt - 1;
          if (mCnt == 1) mAct <= 0;
        end
        if (et && mAct && mPer != 0) begin
          if (mEnvT <= 1) begin
            mEnvT <= mPer;
            if (mUp && mVol < 15) mVol <= mVol + 1;
            else if (!mUp && mVol > 0) mVol <= mVol - 1;
          end else mEnvT <= mEnvT - 1;
        end
        if (baseTick) begin
          if (mDiv == 0) begin
            mDiv <= perOf(mRat, mSh) - 1;
            fb = mLfsr[0] ^ mLfsr[1];
            nl = {fb, mLfsr[14:1]};
            if (mNar) nl[6] = fb;
            mLfsr <= nl;
          end else mDiv <= mDiv - 1;
        end
      end
      mRat <= nRat; mSh <= nSh; mNar <= nNar; mTim <= nTim;
      mVol0 <= nVol0; mUp <= nUp; mPer <= nPer; mLen <= nLen;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      int expAmp;
      expAmp = (mAct && !mLfsr[0]) ? mVol : 0;
      check(amp == 4'(expAmp), "R6 model amp", amp, expAmp);
      check(active == mAct, "R7 model active", active, mAct);
    end
  end

  task automatic wrEnv(input int v, input int up, input int per, input int len);
    envData = 16'((v & 15) | ((up & 1) << 4) | ((per & 7) << 5) | ((len & 63) << 8));
    envWe = 1'b1;
    @(negedge clk);
    envWe = 1'b0;
  endtask

  task automatic wrFrq(input int r, input int s, input int nar, input int tim, input int trg);
    frqData = 16'((r & 7) | ((s & 15) << 3) | ((nar & 1) << 7) | ((tim & 1) << 8) | ((trg & 1) << 9));
    frqWe = 1'b1;
    @(negedge clk);
    frqWe = 1'b0;
  endtask

  task automatic firstOn(output int n);
    n = 0;
    while (amp == 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int n, mx;
    bit allZero;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(active == 1'b0, "R1 active in reset", active, 0);
    check(amp == 4'd0, "R1 amp in reset", amp, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(active == 1'b0, "R1 active after reset", active, 0);
    check(amp == 4'd0, "R1 amp after reset", amp, 0);
    cmpOn = 1'b1;
    baseTick = 1'b1;

    // R2, R5, R3: narrow, ratio 1, shift 0 -> period 2, first 1 after step 7
    wrEnv(9, 0, 0, 0);
    wrFrq(1, 0, 1, 0, 1);
    check(active == 1'b1, "R2 active after trigger", active, 1);
    check(amp == 4'd0, "R2 all-ones reload gives amp 0", amp, 0);
    firstOn(n);
    check(n == 14, "R5 narrow first-one cycle", n, 14);
    check(amp == 4'd9, "R6 amp equals volume", amp, 9);

    // R4: wide mode, first 1 after step 15
    wrFrq(1, 0, 0, 0, 1);
    firstOn(n);
    check(n == 30, "R4 wide first-one cycle", n, 30);

    // R3: ratio 0 counts as half -> period 4 with shift 2
    wrFrq(0, 2, 1, 0, 1);
    firstOn(n);
    check(n == 28, "R3 ratio0 shift2 period", n, 28);
    // R3: ratio 3 shift 1 -> period 12
    wrFrq(3, 1, 1, 0, 1);
    firstOn(n);
    check(n == 84, "R3 ratio3 shift1 period", n, 84);

    // R7: timed, length 60 -> 4 length ticks
    wrEnv(9, 0, 0, 60);
    wrFrq(1, 0, 1, 1, 1);
    waitCyc(12);
    check(active == 1'b1, "R7 still active before expiry", active, 1);
    waitCyc(4);
    check(active == 1'b0, "R7 expired after 4 ticks", active, 0);

    // R10: frequency write without trigger leaves the voice off
    wrFrq(1, 0, 1, 0, 0);
    waitCyc(3);
    check(active == 1'b0, "R10 no restart without trigger", active, 0);

    // R8: untimed note keeps sounding
    wrEnv(9, 0, 0, 63);
    wrFrq(1, 0, 1, 0, 1);
    waitCyc(200);
    check(active == 1'b1, "R8 untimed stays active", active, 1);
    // R10: change settings mid-note without trigger
    wrFrq(2, 0, 1, 0, 0);
    waitCyc(20);
    check(active == 1'b1, "R10 settings write keeps voice", active, 1);

    // R9: rising envelope saturates at 15
    wrEnv(3, 1, 1, 0);
    wrFrq(1, 0, 1, 0, 1);
    waitCyc(200);
    mx = 0;
    for (int i = 0; i < 100; i++) begin
      if (amp > mx) mx = amp;
      @(negedge clk);
    end
    check(mx == 15, "R9 rising envelope peak", mx, 15);

    // R9: falling envelope reaches 0 and stays
    wrEnv(5, 0, 1, 0);
    wrFrq(1, 0, 1, 0, 1);
    waitCyc(200);
    allZero = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (amp != 0) allZero = 1'b0;
      @(negedge clk);
    end
    check(allZero, "R9 falling envelope floor", allZero, 1);
    check(active == 1'b1, "R9 silent but active", active, 1);

    // R9: period 0 freezes volume
    wrEnv(6, 1, 0, 0);
    wrFrq(1, 0, 1, 0, 1);
    waitCyc(150);
    mx = 0;
    for (int i = 0; i < 100; i++) begin
      if (amp > mx) mx = amp;
      @(negedge clk);
    end
    check(mx == 6, "R9 frozen envelope", mx, 6);

    // random phase, compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      baseTick = 1'($urandom % 2);
      if ($urandom % 16 == 0) begin
        envData = 16'($urandom);
        envWe = 1'b1;
      end else envWe = 1'b0;
      if ($urandom % 20 == 0) begin
        frqData = 16'($urandom) & 16'h039F;
        frqWe = 1'b1;
      end else frqWe = 1'b0;
      @(negedge clk);
    end
    envWe = 1'b0;
    frqWe = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule